// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Frame Queue

This block sits behind a CAN protocol engine and decides which completed frames are kept. Each frame arrives as a one-cycle strobe carrying its identifier, the extended-identifier flag, the remote-request flag, the data length code and up to eight data bytes. The frame is compared against a shared table of filter entries. Each entry has its own mask, and a frame is kept when at least one entry accepts it. Kept frames go into a small first-in first-out queue. Software drains that queue through a read port, which shows the oldest frame and the number of the filter entry that accepted it.

The table is a set of 32-bit words with a code word and a mask word for each. A format select input decides how the words are split into entries. One entry per word holds a full extended identifier. Two entries per word hold standard identifiers. Four entries per word hold 8-bit partial identifiers. With the default eight words, the table holds 8, 16 or 32 entries. The queue holds six frames. It raises a level warning at five stored frames and a sticky overflow flag when an accepted frame finds no room.

Top module: `rxf_accept_top`

## Requirements
- R1: After reset the queue is empty: `q_avail`, `q_warn` and `q_ovf` are all 0.
- R2: Define the aligned identifier A[28:0] as `rx_id` when `rx_ide`=1, and as {`rx_id`[10:0], 18 zero bits} when `rx_ide`=0. With `flt_mode`=0 (extended format), entry w uses word w. Its 32-bit key is {rtr at bit 31, ide at bit 30, 0 at bit 29, A at bits 28:0}. The entry matches when every key bit enabled by a 1 in its mask word equals the code word bit.
- R3: With `flt_mode`=1 (standard format), entry e uses bits [16*(e%2)+15 : 16*(e%2)] of word e/2, so the lower half comes first. The 16-bit key is {rtr at bit 15, ide at bit 14, zeros at bits 13:11, A[28:18] at bits 10:0}, compared under the same masking rule.
- R4: With `flt_mode`=2 (partial format), entry e uses bits [8*(e%4)+7 : 8*(e%4)] of word e/4. Its 8-bit key is A[28:21]. The flags take no part in the match.
- R5: A strobed frame that no entry matches is dropped, and the queue does not change. `flt_mode`=3 matches nothing.
- R6: When several entries match, the lowest-numbered entry wins. Its number is stored with the frame and appears on `q_hit`.
- R7: The queue holds up to 6 frames in arrival order. While it is not empty, the outputs show the oldest frame with all of its fields. A `q_pop` removes that frame one cycle later.
- R8: `q_avail` is 1 exactly when at least one frame is stored. A strobed accepted frame is visible on the outputs on the cycle after its strobe.
- R9: `q_warn` is 1 exactly when 5 or more frames are stored.
- R10: An accepted frame that arrives while 6 frames are stored and no pop happens in the same cycle is dropped, and `q_ovf` goes to 1. `q_ovf` stays 1 until `ovf_clr` is pulsed. If a pop and an accepted frame arrive together on a full queue, the frame is stored and no overflow is flagged.
- R11: A `q_pop` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_mode | input | 2 | Table format: 0 extended, 1 standard, 2 partial, 3 none |
| flt_code | input | 256 | Filter code words, word w at bits [32w+31:32w] |
| flt_mask | input | 256 | Filter mask words, same layout; 1 = compare bit |
| rx_stb | input | 1 | Completed-frame strobe |
| rx_id | input | 29 | Received identifier (standard ID in bits 10:0) |
| rx_ide | input | 1 | Extended identifier flag |
| rx_rtr | input | 1 | Remote request flag |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Data bytes |
| q_pop | input | 1 | Remove oldest frame |
| ovf_clr | input | 1 | Clear overflow flag |
| q_avail | output | 1 | Frames available |
| q_warn | output | 1 | Five or more frames stored |
| q_ovf | output | 1 | Sticky overflow |
| q_id | output | 29 | Oldest frame identifier |
| q_ide | output | 1 | Oldest frame extended flag |
| q_rtr | output | 1 | Oldest frame remote flag |
| q_dlc | output | 4 | Oldest frame data length code |
| q_data | output | 64 | Oldest frame data |
| q_hit | output | 5 | Index of the accepting filter entry |

## Verification
The assertions assume that `flt_mode` and the filter table do not change in the cycle a strobe is applied. They also assume that `ovf_clr` and `rx_stb` are single-cycle pulses that are sampled at the clock edge. The bench changes the table only while no strobe is pending. It drives every strobe, pop and clear for exactly one cycle, starting at a falling edge, so each property sees one clean event per edge. Overflow is produced only through a real seventh accepted frame, so the sticky-flag properties are exercised on genuine state.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ID_W   = 29;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        FMT_EXT  = 2'd0,
        FMT_STD  = 2'd1,
        FMT_PART = 2'd2,
        FMT_NONE = 2'd3
    } rxf_fmt_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [3:0]        dlc;
        logic [DATA_W-1:0] data;
    } rxf_frame_t;

    localparam int FRAME_W = $bits(rxf_frame_t);

    // Standard identifiers are left-justified so every format reads the top bits.
    function automatic logic [ID_W-1:0] align_id(input logic [ID_W-1:0] id, input logic ide);
        return ide ? id : {id[10:0], 18'b0};
    endfunction

    function automatic logic [31:0] key_ext(input logic [ID_W-1:0] a, input logic ide, input logic rtr);
        return {rtr, ide, 1'b0, a};
    endfunction

    function automatic logic [15:0] key_std(input logic [ID_W-1:0] a, input logic ide, input logic rtr);
        return {rtr, ide, 3'b000, a[28:18]};
    endfunction

    function automatic logic [7:0] key_part(input logic [ID_W-1:0] a);
        return a[28:21];
    endfunction

endpackage

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = $clog2(WORDS * 4)
) (
    input  logic [1:0]          fmt,
    input  logic [WORDS*32-1:0] code,
    input  logic [WORDS*32-1:0] mask,
    input  logic [ID_W-1:0]     id,
    input  logic                ide,
    input  logic                rtr,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);
    localparam int N_EXT  = WORDS;
    localparam int N_STD  = WORDS * 2;
    localparam int N_PART = WORDS * 4;

    logic [ID_W-1:0]   aid;
    logic [31:0]       k_ext;
    logic [15:0]       k_std;
    logic [7:0]        k_part;
    logic [N_EXT-1:0]  v_ext;
    logic [N_STD-1:0]  v_std;
    logic [N_PART-1:0] v_part;
    logic [N_PART-1:0] cand;

    assign aid    = align_id(id, ide);
    assign k_ext  = key_ext(aid, ide, rtr);
    assign k_std  = key_std(aid, ide, rtr);
    assign k_part = key_part(aid);

    for (genvar w = 0; w < N_EXT; w++) begin : g_ext
        assign v_ext[w] = ~|((k_ext ^ code[w*32 +: 32]) & mask[w*32 +: 32]);
    end

    for (genvar e = 0; e < N_STD; e++) begin : g_std
        assign v_std[e] = ~|((k_std ^ code[e*16 +: 16]) & mask[e*16 +: 16]);
    end

    for (genvar e = 0; e < N_PART; e++) begin : g_part
        assign v_part[e] = ~|((k_part ^ code[e*8 +: 8]) & mask[e*8 +: 8]);
    end

    always_comb begin
        unique case (rxf_fmt_e'(fmt))
            FMT_EXT:  cand = N_PART'(v_ext);
            FMT_STD:  cand = N_PART'(v_std);
            FMT_PART: cand = v_part;
            default:  cand = '0;
        endcase
    end

    // Lowest index has priority.
    always_comb begin
        hit = |cand;
        idx = '0;
        for (int i = N_PART - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rxf_queue.sv
module rxf_queue #(
    parameter int DEPTH   = 6,
    parameter int WARN_AT = 5,
    parameter int WIDTH   = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] dout,
    output logic             avail,
    output logic             warn,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count < CNT_W'(DEPTH)) || pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !push_ok) ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;
        end
    end

    assign dout  = mem[rd_ptr];
    assign avail = (count != '0);
    assign warn  = (count >= CNT_W'(WARN_AT));

endmodule

// File: rtl/rxf_accept_top.sv
module rxf_accept_top
    import rxf_pkg::*;
#(
    parameter int FLT_WORDS  = 8,
    parameter int FIFO_DEPTH = 6,
    parameter int WARN_LEVEL = 5,
    parameter int HIT_W      = $clog2(FLT_WORDS * 4)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             flt_mode,
    input  logic [FLT_WORDS*32-1:0] flt_code,
    input  logic [FLT_WORDS*32-1:0] flt_mask,
    input  logic                   rx_stb,
    input  logic [28:0]            rx_id,
    input  logic                   rx_ide,
    input  logic                   rx_rtr,
    input  logic [3:0]             rx_dlc,
    input  logic [63:0]            rx_data,
    input  logic                   q_pop,
    input  logic                   ovf_clr,
    output logic                   q_avail,
    output logic                   q_warn,
    output logic                   q_ovf,
    output logic [28:0]            q_id,
    output logic                   q_ide,
    output logic                   q_rtr,
    output logic [3:0]             q_dlc,
    output logic [63:0]            q_data,
    output logic [HIT_W-1:0]       q_hit
);
    localparam int ENTRY_W = FRAME_W + HIT_W;

    logic               m_hit;
    logic [HIT_W-1:0]   m_idx;
    rxf_frame_t         in_frame, out_frame;
    logic [ENTRY_W-1:0] q_in, q_out;

    assign in_frame = '{id: rx_id, ide: rx_ide, rtr: rx_rtr, dlc: rx_dlc, data: rx_data};

    rxf_match #(
        .WORDS (FLT_WORDS),
        .IDX_W (HIT_W)
    ) u_match (
        .fmt  (flt_mode),
        .code (flt_code),
        .mask (flt_mask),
        .id   (rx_id),
        .ide  (rx_ide),
        .rtr  (rx_rtr),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    assign q_in = {in_frame, m_idx};

    rxf_queue #(
        .DEPTH   (FIFO_DEPTH),
        .WARN_AT (WARN_LEVEL),
        .WIDTH   (ENTRY_W)
    ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_stb && m_hit),
        .din     (q_in),
        .pop     (q_pop),
        .ovf_clr (ovf_clr),
        .dout    (q_out),
        .avail   (q_avail),
        .warn    (q_warn),
        .ovf     (q_ovf)
    );

    assign {out_frame, q_hit} = q_out;
    assign q_id   = out_frame.id;
    assign q_ide  = out_frame.ide;
    assign q_rtr  = out_frame.rtr;
    assign q_dlc  = out_frame.dlc;
    assign q_data = out_frame.data;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  flt_mode,
    input logic        rx_stb,
    input logic        q_pop,
    input logic        ovf_clr,
    input logic        q_avail,
    input logic        q_warn,
    input logic        q_ovf,
    input logic [28:0] q_id
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!q_avail && !q_warn && !q_ovf));

    a_r5_no_format_no_store: assert property (@(posedge clk) disable iff (rst)
        (rx_stb && flt_mode == 2'd3 && !q_avail) |=> !q_avail);

    a_r7_head_holds: assert property (@(posedge clk) disable iff (rst)
        (q_avail && !q_pop) |=> (q_avail && $stable(q_id)));

    a_r9_warn_implies_avail: assert property (@(posedge clk) disable iff (rst)
        q_warn |-> q_avail);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (q_ovf && !ovf_clr) |=> q_ovf);

    a_r10_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !rx_stb) |=> !q_ovf);

    a_r11_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (!q_avail && q_pop && !rx_stb) |=> (!q_avail && !q_warn));
endmodule

bind rxf_accept_top rxf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .flt_mode (flt_mode),
    .rx_stb   (rx_stb),
    .q_pop    (q_pop),
    .ovf_clr  (ovf_clr),
    .q_avail  (q_avail),
    .q_warn   (q_warn),
    .q_ovf    (q_ovf),
    .q_id     (q_id)
);

// File: tb/rxf_accept_top_tb.sv
module rxf_accept_top_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   flt_mode = 2'd0;
    logic [255:0] flt_code = '0;
    logic [255:0] flt_mask = '0;
    logic         rx_stb = 1'b0;
    logic [28:0]  rx_id = '0;
    logic         rx_ide = 1'b0;
    logic         rx_rtr = 1'b0;
    logic [3:0]   rx_dlc = '0;
    logic [63:0]  rx_data = '0;
    logic         q_pop = 1'b0;
    logic         ovf_clr = 1'b0;
    logic         q_avail, q_warn, q_ovf, q_ide, q_rtr;
    logic [28:0]  q_id;
    logic [3:0]   q_dlc;
    logic [63:0]  q_data;
    logic [4:0]   q_hit;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rxf_accept_top u_dut (
        .clk(clk), .rst(rst), .flt_mode(flt_mode), .flt_code(flt_code), .flt_mask(flt_mask),
        .rx_stb(rx_stb), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc),
        .rx_data(rx_data), .q_pop(q_pop), .ovf_clr(ovf_clr), .q_avail(q_avail), .q_warn(q_warn),
        .q_ovf(q_ovf), .q_id(q_id), .q_ide(q_ide), .q_rtr(q_rtr), .q_dlc(q_dlc),
        .q_data(q_data), .q_hit(q_hit)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        ide;
        logic        rtr;
        logic [28:0] id;
        logic        acc;
        logic [4:0]  hit;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 29'h0ABCDE01, 1'b1, 5'd0},
        '{2'd0, 1'b1, 1'b0, 29'h123456AB, 1'b1, 5'd1},
        '{2'd0, 1'b1, 1'b0, 29'h123457AB, 1'b0, 5'd0},
        '{2'd0, 1'b0, 1'b0, 29'h00000123, 1'b1, 5'd2},
        '{2'd0, 1'b0, 1'b1, 29'h00000123, 1'b1, 5'd3},
        '{2'd0, 1'b1, 1'b1, 29'h0ABCDE01, 1'b1, 5'd3},
        '{2'd0, 1'b0, 1'b0, 29'h00000124, 1'b0, 5'd0},
        '{2'd1, 1'b0, 1'b0, 29'h00000555, 1'b1, 5'd0},
        '{2'd1, 1'b0, 1'b0, 29'h0000055A, 1'b1, 5'd1},
        '{2'd1, 1'b0, 1'b1, 29'h0000055A, 1'b0, 5'd0},
        '{2'd1, 1'b1, 1'b0, 29'h1FFEAAAA, 1'b1, 5'd2},
        '{2'd1, 1'b0, 1'b0, 29'h000007FF, 1'b0, 5'd0},
        '{2'd2, 1'b0, 1'b0, 29'h0000052B, 1'b1, 5'd0},
        '{2'd2, 1'b1, 1'b0, 29'h09801234, 1'b1, 5'd1},
        '{2'd2, 1'b0, 1'b1, 29'h0000052B, 1'b1, 5'd0},
        '{2'd2, 1'b1, 1'b0, 29'h00000001, 1'b1, 5'd31},
        '{2'd3, 1'b1, 1'b0, 29'h00000001, 1'b0, 5'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m);
        flt_mode = m;
        case (m)
            2'd0: begin
                flt_code = {{4{32'h20000000}}, 32'h80000000, 32'h048C0000, 32'h52345600, 32'h4ABCDE01};
                flt_mask = {{4{32'hFFFFFFFF}}, 32'h80000000, 32'hFFFC0000, 32'hFFFFFF00, 32'hFFFFFFFF};
            end
            2'd1: begin
                flt_code = {{6{32'h38003800}}, 32'h380047FF, 32'h05500555};
                flt_mask = {{6{32'hFFFFFFFF}}, 32'hFFFFC7FF, 32'hC7F0FFFF};
            end
            default: begin
                flt_code = {32'h00FFFFFF, {6{32'hFFFFFFFF}}, 32'hFFFF40A5};
                flt_mask = {32'h00FFFFFF, {6{32'hFFFFFFFF}}, 32'hFFFFF0FF};
            end
        endcase
    endtask

    task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                        input logic [3:0] dlc, input logic [63:0] data, input logic pop);
        @(negedge clk);
        rx_stb = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr;
        rx_dlc = dlc; rx_data = data; q_pop = pop;
        @(negedge clk);
        rx_stb = 1'b0; q_pop = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    task automatic clr_ovf();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 avail", 64'(q_avail), 64'd0);
        chk("R1 warn", 64'(q_warn), 64'd0);
        chk("R1 ovf", 64'(q_ovf), 64'd0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].mode)
                2'd0:    tag = "R2";
                2'd1:    tag = "R3";
                2'd2:    tag = "R4";
                default: tag = "R5";
            endcase
            set_cfg(VECS[i].mode);
            send(VECS[i].id, VECS[i].ide, VECS[i].rtr, 4'(i % 9), {8{8'(i)}}, 1'b0);
            chk({tag, " accept"}, 64'(q_avail), 64'(VECS[i].acc));
            if (VECS[i].acc) begin
                chk({tag, " R6 hit index"}, 64'(q_hit), 64'(VECS[i].hit));
                chk({tag, " R7 id"}, 64'(q_id), 64'(VECS[i].id));
                chk({tag, " R7 flags"}, 64'({q_ide, q_rtr}), 64'({VECS[i].ide, VECS[i].rtr}));
                chk({tag, " R7 dlc"}, 64'(q_dlc), 64'(i % 9));
                chk({tag, " R7 data"}, q_data, {8{8'(i)}});
                pop_one();
                chk({tag, " R8 empty after pop"}, 64'(q_avail), 64'd0);
            end
        end

        // Fill the queue with catch-all partial matches (entry 31).
        set_cfg(2'd2);
        for (int k = 1; k <= 6; k++) begin
            send(29'(k), 1'b1, 1'b0, 4'd8, 64'(k), 1'b0);
            chk("R8 avail while filling", 64'(q_avail), 64'd1);
            chk("R9 warn level", 64'(q_warn), 64'(k >= 5));
        end
        chk("R10 no ovf at six", 64'(q_ovf), 64'd0);
        send(29'd7, 1'b1, 1'b0, 4'd8, 64'd7, 1'b0);
        chk("R10 ovf set", 64'(q_ovf), 64'd1);
        chk("R7 head kept on overflow", 64'(q_id), 64'd1);
        for (int k = 1; k <= 6; k++) begin
            chk("R7 order", 64'(q_id), 64'(k));
            chk("R6 catch-all index", 64'(q_hit), 64'd31);
            pop_one();
        end
        chk("R8 empty after drain", 64'(q_avail), 64'd0);
        chk("R10 ovf sticky", 64'(q_ovf), 64'd1);

        pop_one();
        chk("R11 pop empty stays empty", 64'(q_avail), 64'd0);
        chk("R11 pop empty warn", 64'(q_warn), 64'd0);
        send(29'd40, 1'b1, 1'b0, 4'd1, 64'd40, 1'b0);
        chk("R11 pointer intact", 64'(q_id), 64'd40);

        clr_ovf();
        chk("R10 ovf cleared", 64'(q_ovf), 64'd0);

        for (int k = 41; k <= 45; k++) send(29'(k), 1'b1, 1'b0, 4'd1, 64'(k), 1'b0);
        send(29'd99, 1'b1, 1'b0, 4'd2, 64'd99, 1'b1);
        chk("R10 push with pop when full", 64'(q_ovf), 64'd0);
        chk("R10 head advanced", 64'(q_id), 64'd41);
        for (int k = 0; k < 5; k++) pop_one();
        chk("R10 last stored frame", 64'(q_id), 64'd99);
        pop_one();
        chk("R8 final empty", 64'(q_avail), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule